// File: doc/BRIEF.md
# FIFO Threshold DMA Request Generator

This block produces the two DMA request lines of a serial bus controller: one asking the DMA engine to refill the transmit FIFO and one asking it to empty the receive FIFO. It does not hold any FIFO storage. It watches the occupancy levels reported by the two FIFOs, the DMA-side push and pop strobes, and a count of bytes left in the current transfer. From these it decides when each burst starts and when it is complete. Both request lines are active-low.

Each direction has its own 6-bit threshold field, and a burst is that value plus one. The burst is capped at the FIFO depth selected by a 2-bit code. A transmit burst starts only once the transmit FIFO has run empty. It ends after exactly the burst count of pushes. A receive burst starts once enough bytes are waiting and ends after the matching count of pops. With draining enabled, the last burst of a transfer shrinks to the bytes that remain, so the DMA engine never asks for data that will not come. Setting both thresholds to zero gives one-byte bursts, which suits single-master camera-bus operation.

A sticky access-error flag records any DMA push into a full transmit FIFO and any DMA pop from an empty receive FIFO. A write-one-to-clear strobe clears it.

Top module: `dma_req_gen`

## Requirements
- R1: While idle, the transmit request `tx_req_no` goes low at the first clock edge at which `tx_lvl_i` is sampled as 0, unless draining is on with `xfer_rem_i` equal to 0.
- R2: A transmit request goes high again at the clock edge that takes the burst-length-th `tx_push_i`. The burst length is `tx_thr_i`+1, capped at the FIFO depth.
- R3: While a request is low and the DMA side makes no push (transmit) or no pop (receive), the request stays low, for any number of cycles.
- R4: `depth_code_i` selects the FIFO depth: 0 selects 8 bytes, 1 selects 16, 2 selects 32 and 3 selects 64. Every burst length is capped at that depth.
- R5: While idle, the receive request `rx_req_no` goes low at the first edge at which `rx_lvl_i` is at least the receive burst length (`rx_thr_i`+1, capped). It goes high at the edge that takes that number of `rx_pop_i` strobes.
- R6: When `drain_en_i` is 1 and 0 < `xfer_rem_i` < the capped burst length, the transmit burst is `xfer_rem_i` bytes. In the same case the receive request starts once `rx_lvl_i` ≥ `xfer_rem_i`, and its burst is `xfer_rem_i` pops. With `drain_en_i` 1 and `xfer_rem_i` 0, no new request starts.
- R7: `acc_err_o` is set at the edge after a `tx_push_i` while `tx_lvl_i` equals the depth, or after an `rx_pop_i` while `rx_lvl_i` is 0. It stays set until an `err_clr_i` cycle that has no new error. If a new error and the clear arrive in the same cycle, the flag stays set.
- R8: The burst length is latched when a request asserts. A threshold change during a burst applies only from the next assertion.
- R9: During and after reset, both request outputs are high and `acc_err_o` is low.
- R10: A threshold value of 0 gives one-byte bursts: the request goes high after a single push or pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_thr_i | input | THR_W | Transmit threshold; burst = value + 1 |
| rx_thr_i | input | THR_W | Receive threshold; burst = value + 1 |
| depth_code_i | input | 2 | FIFO depth select (8 << code bytes) |
| drain_en_i | input | 1 | Enable shortened final burst |
| xfer_rem_i | input | REM_W | Bytes remaining in the current transfer |
| tx_lvl_i | input | LVL_W | Transmit FIFO occupancy |
| tx_push_i | input | 1 | DMA write into the transmit FIFO |
| rx_lvl_i | input | LVL_W | Receive FIFO occupancy |
| rx_pop_i | input | 1 | DMA read from the receive FIFO |
| err_clr_i | input | 1 | Write-one-to-clear for the access error |
| tx_req_no | output | 1 | Transmit DMA request, active low |
| rx_req_no | output | 1 | Receive DMA request, active low |
| acc_err_o | output | 1 | Sticky access-error flag |

## Verification
The hardest case to reach is a change of threshold in the middle of a transmit burst. The new value has to be ignored until the next assertion. The bench raises a burst of four with a threshold of 3. It pushes once, drops the threshold to 0, and then shows that the request stays low until the fourth push. It also holds a transmit burst partly filled across idle cycles. It drives the draining case in both directions with a remaining count below the cap. Finally, it sends an error and a clear strobe in the same cycle to show that the error takes priority.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  localparam int CH_TX = 0;
  localparam int CH_RX = 1;
  localparam int N_CH  = 2;
endpackage

// File: rtl/burst_sizer.sv
module burst_sizer #(
  parameter int THR_W      = 6,
  parameter int LVL_W      = 7,
  parameter int REM_W      = 16,
  parameter int BASE_DEPTH = 8
) (
  input  logic [THR_W-1:0] tx_thr_i,
  input  logic [THR_W-1:0] rx_thr_i,
  input  logic [1:0]       depth_code_i,
  input  logic             drain_en_i,
  input  logic [REM_W-1:0] xfer_rem_i,
  input  logic [LVL_W-1:0] tx_lvl_i,
  input  logic [LVL_W-1:0] rx_lvl_i,
  output logic [LVL_W-1:0] depth_o,
  output logic             tx_start_o,
  output logic [LVL_W-1:0] tx_len_o,
  output logic             rx_start_o,
  output logic [LVL_W-1:0] rx_len_o
);
  localparam int CW = (LVL_W > REM_W) ? LVL_W : REM_W;

  logic [LVL_W-1:0] tx_full, rx_full, tx_cap, rx_cap;
  logic [CW-1:0]    rem_w;
  logic             rem_zero, tx_short, rx_short;

  always_comb begin
    depth_o  = LVL_W'(BASE_DEPTH) << depth_code_i;
    tx_full  = LVL_W'(tx_thr_i) + LVL_W'(1);
    rx_full  = LVL_W'(rx_thr_i) + LVL_W'(1);
    tx_cap   = (tx_full > depth_o) ? depth_o : tx_full;
    rx_cap   = (rx_full > depth_o) ? depth_o : rx_full;
    rem_w    = CW'(xfer_rem_i);
    rem_zero = (xfer_rem_i == '0);
    tx_short = drain_en_i && !rem_zero && (rem_w < CW'(tx_cap));
    rx_short = drain_en_i && !rem_zero && (rem_w < CW'(rx_cap));

    tx_start_o = (tx_lvl_i == '0) && !(drain_en_i && rem_zero);
    tx_len_o   = tx_short ? LVL_W'(xfer_rem_i) : tx_cap;

    if (drain_en_i)
      rx_start_o = !rem_zero && (rx_short ? (CW'(rx_lvl_i) >= rem_w) : (rx_lvl_i >= rx_cap));
    else
      rx_start_o = (rx_lvl_i >= rx_cap);
    rx_len_o   = rx_short ? LVL_W'(xfer_rem_i) : rx_cap;
  end
endmodule

// File: rtl/req_chan.sv
module req_chan #(
  parameter int LVL_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LVL_W-1:0] len_i,
  input  logic             xfer_i,
  output logic             busy_o
);
  logic [LVL_W-1:0] left_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else if (!busy_q) begin
      if (start_i && len_i != '0) begin
        busy_q <= 1'b1;
        left_q <= len_i;  // burst length frozen here
      end
    end else if (xfer_i) begin
      if (left_q == LVL_W'(1)) begin
        busy_q <= 1'b0;
        left_q <= '0;
      end else begin
        left_q <= left_q - LVL_W'(1);
      end
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/acc_err_det.sv
module acc_err_det #(
  parameter int LVL_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_push_i,
  input  logic [LVL_W-1:0] tx_lvl_i,
  input  logic [LVL_W-1:0] depth_i,
  input  logic             rx_pop_i,
  input  logic [LVL_W-1:0] rx_lvl_i,
  input  logic             clr_i,
  output logic             err_o
);
  logic hit, err_q;

  assign hit = (tx_push_i && tx_lvl_i >= depth_i) || (rx_pop_i && rx_lvl_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    err_q <= 1'b0;
    else if (hit)   err_q <= 1'b1;  // set beats clear
    else if (clr_i) err_q <= 1'b0;
  end

  assign err_o = err_q;
endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen
  import dma_req_pkg::*;
#(
  parameter int THR_W = 6,
  parameter int LVL_W = 7,
  parameter int REM_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [THR_W-1:0] tx_thr_i,
  input  logic [THR_W-1:0] rx_thr_i,
  input  logic [1:0]       depth_code_i,
  input  logic             drain_en_i,
  input  logic [REM_W-1:0] xfer_rem_i,
  input  logic [LVL_W-1:0] tx_lvl_i,
  input  logic             tx_push_i,
  input  logic [LVL_W-1:0] rx_lvl_i,
  input  logic             rx_pop_i,
  input  logic             err_clr_i,
  output logic             tx_req_no,
  output logic             rx_req_no,
  output logic             acc_err_o
);
  logic [LVL_W-1:0] depth;
  logic             start [N_CH];
  logic [LVL_W-1:0] len   [N_CH];
  logic             xfer  [N_CH];
  logic             busy  [N_CH];

  burst_sizer #(.THR_W(THR_W), .LVL_W(LVL_W), .REM_W(REM_W)) i_sizer (
    .tx_thr_i    (tx_thr_i),
    .rx_thr_i    (rx_thr_i),
    .depth_code_i(depth_code_i),
    .drain_en_i  (drain_en_i),
    .xfer_rem_i  (xfer_rem_i),
    .tx_lvl_i    (tx_lvl_i),
    .rx_lvl_i    (rx_lvl_i),
    .depth_o     (depth),
    .tx_start_o  (start[CH_TX]),
    .tx_len_o    (len[CH_TX]),
    .rx_start_o  (start[CH_RX]),
    .rx_len_o    (len[CH_RX])
  );

  assign xfer[CH_TX] = tx_push_i;
  assign xfer[CH_RX] = rx_pop_i;

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    req_chan #(.LVL_W(LVL_W)) i_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(start[c]),
      .len_i  (len[c]),
      .xfer_i (xfer[c]),
      .busy_o (busy[c])
    );
  end

  assign tx_req_no = ~busy[CH_TX];
  assign rx_req_no = ~busy[CH_RX];

  acc_err_det #(.LVL_W(LVL_W)) i_err (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tx_push_i(tx_push_i),
    .tx_lvl_i (tx_lvl_i),
    .depth_i  (depth),
    .rx_pop_i (rx_pop_i),
    .rx_lvl_i (rx_lvl_i),
    .clr_i    (err_clr_i),
    .err_o    (acc_err_o)
  );
endmodule

// File: rtl/dma_req_gen_chk.sv
module dma_req_gen_chk #(
  parameter int THR_W = 6,
  parameter int LVL_W = 7,
  parameter int REM_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       depth_code_i,
  input logic             drain_en_i,
  input logic [REM_W-1:0] xfer_rem_i,
  input logic [LVL_W-1:0] tx_lvl_i,
  input logic             tx_push_i,
  input logic [LVL_W-1:0] rx_lvl_i,
  input logic             rx_pop_i,
  input logic             err_clr_i,
  input logic             tx_req_no,
  input logic             rx_req_no,
  input logic             acc_err_o
);
  logic [LVL_W-1:0] full_lvl;
  assign full_lvl = LVL_W'(8) << depth_code_i;

  p_tx_rise_empty_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_req_no) |-> $past(tx_lvl_i) == '0);

  p_tx_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_req_no && !tx_push_i) |=> !tx_req_no);

  p_rx_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_req_no && !rx_pop_i) |=> !rx_req_no);

  p_rx_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_req_no) |-> $past(rx_lvl_i) != '0);

  p_drain_none_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drain_en_i && xfer_rem_i == '0 && tx_req_no) |=> tx_req_no);

  p_err_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((tx_push_i && tx_lvl_i == full_lvl) || (rx_pop_i && rx_lvl_i == '0)) |=> acc_err_o);

  p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_err_o && !err_clr_i) |=> acc_err_o);
endmodule

bind dma_req_gen dma_req_gen_chk #(.THR_W(THR_W), .LVL_W(LVL_W), .REM_W(REM_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .depth_code_i(depth_code_i),
  .drain_en_i  (drain_en_i),
  .xfer_rem_i  (xfer_rem_i),
  .tx_lvl_i    (tx_lvl_i),
  .tx_push_i   (tx_push_i),
  .rx_lvl_i    (rx_lvl_i),
  .rx_pop_i    (rx_pop_i),
  .err_clr_i   (err_clr_i),
  .tx_req_no   (tx_req_no),
  .rx_req_no   (rx_req_no),
  .acc_err_o   (acc_err_o)
);

// File: tb/test_dma_req_gen.sv
module test_dma_req_gen;
  localparam int CLK_PERIOD = 10;
  localparam int THR_W = 6;
  localparam int LVL_W = 7;
  localparam int REM_W = 16;

  typedef struct packed {
    logic [5:0]  thr;
    logic [1:0]  code;
    logic        drain;
    logic [15:0] rem;
    logic [6:0]  burst;
  } vec_t;

  localparam int N_VEC = 7;
  localparam vec_t TBL [N_VEC] = '{
    '{6'd0,  2'd3, 1'b0, 16'd0,  7'd1},   // R10 single byte
    '{6'd3,  2'd3, 1'b0, 16'd0,  7'd4},   // R2
    '{6'd15, 2'd0, 1'b0, 16'd0,  7'd8},   // R4 capped at 8
    '{6'd20, 2'd1, 1'b0, 16'd0,  7'd16},  // R4 capped at 16
    '{6'd7,  2'd2, 1'b1, 16'd3,  7'd3},   // R6 shortened
    '{6'd7,  2'd2, 1'b1, 16'd20, 7'd8},   // R6 remaining above cap
    '{6'd63, 2'd3, 1'b0, 16'd0,  7'd64}   // R4 full 64
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [THR_W-1:0] tx_thr_i = '0, rx_thr_i = 6'd7;
  logic [1:0]       depth_code_i = 2'd3;
  logic             drain_en_i = 1'b0;
  logic [REM_W-1:0] xfer_rem_i = '0;
  logic [LVL_W-1:0] tx_lvl_i = 7'd1, rx_lvl_i = '0;
  logic             tx_push_i = 1'b0, rx_pop_i = 1'b0, err_clr_i = 1'b0;
  logic             tx_req_no, rx_req_no, acc_err_o;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dma_req_gen #(.THR_W(THR_W), .LVL_W(LVL_W), .REM_W(REM_W)) i_dma_req_gen (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    repeat (3) step();
    chk("R9 tx_req_no in reset", tx_req_no, 1);
    chk("R9 rx_req_no in reset", rx_req_no, 1);
    chk("R9 acc_err_o in reset", acc_err_o, 0);
    rst_ni = 1'b1;
    step();
    chk("R9 tx_req_no after reset", tx_req_no, 1);

    // table: transmit bursts (R1 R2 R4 R6 R10)
    for (int v = 0; v < N_VEC; v++) begin
      tx_thr_i = TBL[v].thr; depth_code_i = TBL[v].code;
      drain_en_i = TBL[v].drain; xfer_rem_i = TBL[v].rem;
      tx_lvl_i = '0;
      step();
      chk($sformatf("R1 row %0d assert", v), tx_req_no, 0);
      tx_lvl_i = 7'd1;
      tx_push_i = 1'b1;
      for (int p = 1; p <= int'(TBL[v].burst); p++) begin
        step();
        if (p < int'(TBL[v].burst))
          chk($sformatf("R2 row %0d held after %0d pushes", v, p), tx_req_no, 0);
        else
          chk($sformatf("R2 row %0d released after %0d pushes", v, p), tx_req_no, 1);
      end
      tx_push_i = 1'b0;
      step();
      chk($sformatf("R2 row %0d stays idle", v), tx_req_no, 1);
    end
    drain_en_i = 1'b0; xfer_rem_i = '0; depth_code_i = 2'd3;

    // R3: partial burst held across idle cycles
    tx_thr_i = 6'd3; tx_lvl_i = '0;
    step();
    chk("R1 assert for R3 test", tx_req_no, 0);
    tx_lvl_i = 7'd1; tx_push_i = 1'b1;
    step(); step();
    tx_push_i = 1'b0;
    repeat (5) step();
    chk("R3 tx held after 2 of 4 pushes", tx_req_no, 0);
    tx_push_i = 1'b1;
    step();
    chk("R3 tx held after 3 of 4 pushes", tx_req_no, 0);
    step();
    chk("R3 tx released after 4 pushes", tx_req_no, 1);
    tx_push_i = 1'b0;

    // R8: threshold change mid-burst
    tx_thr_i = 6'd3; tx_lvl_i = '0;
    step();
    chk("R8 assert", tx_req_no, 0);
    tx_lvl_i = 7'd1; tx_push_i = 1'b1;
    step();
    tx_thr_i = 6'd0;
    step();
    chk("R8 still low after 2 pushes", tx_req_no, 0);
    step();
    chk("R8 still low after 3 pushes", tx_req_no, 0);
    step();
    chk("R8 released after 4 pushes", tx_req_no, 1);
    tx_push_i = 1'b0;

    // R6: drain with nothing remaining starts nothing
    drain_en_i = 1'b1; xfer_rem_i = '0; tx_lvl_i = '0;
    step(); step();
    chk("R6 no tx request when remaining is 0", tx_req_no, 1);
    tx_lvl_i = 7'd1; drain_en_i = 1'b0;
    step();

    // R5: receive burst of 4
    rx_thr_i = 6'd3; rx_lvl_i = 7'd3;
    step();
    chk("R5 rx idle below burst", rx_req_no, 1);
    rx_lvl_i = 7'd4;
    step();
    chk("R5 rx asserts at burst", rx_req_no, 0);
    rx_pop_i = 1'b1;
    step(); step(); step();
    chk("R5 rx held after 3 pops", rx_req_no, 0);
    step();
    rx_pop_i = 1'b0; rx_lvl_i = '0;
    chk("R5 rx released after 4 pops", rx_req_no, 1);
    step();
    chk("R5 rx stays idle", rx_req_no, 1);

    // R6: receive drain, 3 remaining
    rx_thr_i = 6'd7; drain_en_i = 1'b1; xfer_rem_i = 16'd3; rx_lvl_i = 7'd2;
    step();
    chk("R6 rx idle with 2 of 3 remaining", rx_req_no, 1);
    rx_lvl_i = 7'd3;
    step();
    chk("R6 rx asserts with all 3 present", rx_req_no, 0);
    rx_pop_i = 1'b1;
    step(); step();
    chk("R6 rx held after 2 pops", rx_req_no, 0);
    step();
    rx_pop_i = 1'b0; rx_lvl_i = '0; xfer_rem_i = '0;
    chk("R6 rx released after 3 pops", rx_req_no, 1);
    drain_en_i = 1'b0;
    step();

    // R7: access error
    chk("R7 no error so far", acc_err_o, 0);
    depth_code_i = 2'd0; tx_lvl_i = 7'd8; tx_push_i = 1'b1;
    step();
    tx_push_i = 1'b0;
    chk("R7 push into full sets error", acc_err_o, 1);
    repeat (3) step();
    chk("R7 error sticky", acc_err_o, 1);
    err_clr_i = 1'b1;
    step();
    err_clr_i = 1'b0;
    chk("R7 clear", acc_err_o, 0);
    rx_lvl_i = '0; rx_pop_i = 1'b1; err_clr_i = 1'b1;
    step();
    rx_pop_i = 1'b0;
    chk("R7 pop from empty wins over clear", acc_err_o, 1);
    step();
    err_clr_i = 1'b0;
    chk("R7 clear after pop error", acc_err_o, 0);
    tx_lvl_i = 7'd7; tx_push_i = 1'b1;
    step();
    tx_push_i = 1'b0;
    chk("R7 push below full no error", acc_err_o, 0);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule